// File: doc/BRIEF.md
# DRAM Read-to-Write Turnaround Sequencer

This block drives the command bus of a DDR SDRAM on behalf of a simple requester. It issues one command per clock. Read and write requests arrive with a bank and a row. The block opens rows when they are needed and records, for each bank, whether a row is open and which one. When a write arrives while a read burst is still returning data, the block ends that burst in one of two ways, depending on how the write's bank and row compare with the read's.

If the write goes to the same bank and row as the read, or to a different bank, the block issues a burst-stop. It then holds the write for a settling wait of at least the CAS latency, so that the data bus has gone to high impedance. If the write goes to the read's bank but to another row, no burst-stop is used. The block precharges that bank, which ends the read, then reactivates it with the new row, and issues the write after the activate-to-access delay. Every clock slot without a useful command carries NOP.

The requester holds a request together with its bank and row until the matching grant is seen. The grant rises in the same cycle that the READ or WRIT command is on the bus.

Top module: `ddr_rw_turnaround`

## Requirements
- R1: While reset is high, and in the first cycle after it, `cmd` is NOP (code 0) and both grants are low. After reset every bank is treated as closed.
- R2: Command codes on `cmd` are NOP=0, READ=1, WRIT=2, BST=3, PRE=4, ACT=5. Every slot without a scheduled command is NOP. `cmd_bank` and `cmd_row` carry the request's bank and row with every non-NOP command. ACT is only sent to a closed bank. READ and WRIT are only sent to a bank that is open on the requested row.
- R3: A request to a closed bank gives ACT in the cycle after the request is sampled. READ or WRIT follows exactly T_RCD cycles after the ACT.
- R4: A request to a bank that is open on another row gives PRE. ACT follows exactly T_RP cycles later, and READ or WRIT follows exactly T_RCD cycles after the ACT.
- R5: A read to a bank that is open on the requested row gives READ in the cycle after the request is sampled, with `rd_gnt` high in that cycle.
- R6: A write that interrupts a read in the same bank and row gives BST, then WRIT exactly the effective burst-stop wait later, with `wr_gnt` high in the WRIT cycle.
- R7: A write that interrupts a read in the same bank but on another row issues no BST. It gives PRE, ACT after T_RP, and WRIT after T_RCD.
- R8: A write that interrupts a read in a different bank gives BST. After the effective burst-stop wait it continues with the target bank's own path: WRIT if that bank is open on the row, otherwise the R3 or R4 sequence.
- R9: The effective burst-stop wait is the larger of T_BSTW and CL.
- R10: A write counts as interrupting a read only if it is sampled within CL+BL/2 clock edges after the edge that issued the READ, and no BST or PRE has been issued since. Otherwise it takes the plain path with no BST.
- R11: When both requests are pending in the same cycle, the write is served first.
- R12: Each grant lasts exactly one cycle. The cycle after a grant is NOP, and a request still held during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, held until `rd_gnt` |
| rd_bank | input | BANK_W | Bank of the read |
| rd_row | input | ROW_W | Row of the read |
| wr_req | input | 1 | Write request, held until `wr_gnt` |
| wr_bank | input | BANK_W | Bank of the write |
| wr_row | input | ROW_W | Row of the write |
| rd_gnt | output | 1 | High in the cycle READ is on the bus |
| wr_gnt | output | 1 | High in the cycle WRIT is on the bus |
| cmd | output | 3 | Command code (see R2) |
| cmd_bank | output | BANK_W | Bank of the command, 0 on NOP |
| cmd_row | output | ROW_W | Row of the command, 0 on NOP |

## Verification
The bench builds the block with four banks, 8-bit rows, CL=2 and BL=4, so the read window is four edges. T_RP is 3 and T_RCD is 4. These two delays differ, which means the bench can tell a precharge gap apart from an activate gap. T_BSTW is set to 1, below CL, so every burst-stop gap shows that the wait is raised to CL=2. Rows are drawn from a set of three, which makes hits, misses and different-bank interrupts frequent. Directed writes land on both sides of the four-edge window.

// File: rtl/ddr_turn_pkg.sv
package ddr_turn_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_READ = 3'd1,
    CMD_WRIT = 3'd2,
    CMD_BST  = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_ACT  = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BSTW,
    S_PREW,
    S_ACTW,
    S_HOLD
  } seq_st_e;

endpackage

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NBANK = 4,
  parameter int ROW_W = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     act_en,
  input  logic                     pre_en,
  input  logic                     rw_en,
  input  logic [$clog2(NBANK)-1:0] c_bank,
  input  logic [ROW_W-1:0]         c_row,
  input  logic [$clog2(NBANK)-1:0] q_bank,
  input  logic [ROW_W-1:0]         q_row,
  output logic                     q_open,
  output logic                     q_hit
);
  localparam int BANK_W = $clog2(NBANK);

  logic             open_r [NBANK];
  logic [ROW_W-1:0] row_r  [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_r[g] <= 1'b0;
      end else if (act_en && c_bank == BANK_W'(g)) begin
        open_r[g] <= 1'b1;
      end else if (pre_en && c_bank == BANK_W'(g)) begin
        open_r[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (act_en && c_bank == BANK_W'(g)) row_r[g] <= c_row;
    end
  end

  assign q_open = open_r[q_bank];
  assign q_hit  = (row_r[q_bank] == q_row);

  assert_act_closed_R2: assert property (@(posedge clk) disable iff (rst)
    act_en |-> !open_r[c_bank]);

  assert_access_open_row_R2: assert property (@(posedge clk) disable iff (rst)
    rw_en |-> (open_r[c_bank] && row_r[c_bank] == c_row));

  assert_pre_open_R4: assert property (@(posedge clk) disable iff (rst)
    pre_en |-> open_r[c_bank]);

endmodule

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  assert_no_reload_busy_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> done);

endmodule

// File: rtl/ddr_read_window.sv
module ddr_read_window #(
  parameter int WIN    = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic              stop,
  input  logic [BANK_W-1:0] i_bank,
  input  logic [ROW_W-1:0]  i_row,
  output logic              busy,
  output logic [BANK_W-1:0] r_bank,
  output logic [ROW_W-1:0]  r_row
);
  localparam int LW = $clog2(WIN + 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      r_bank <= '0;
      r_row  <= '0;
    end else if (rd_issue) begin
      left   <= LW'(WIN);
      r_bank <= i_bank;
      r_row  <= i_row;
    end else if (stop) begin
      left   <= '0;
    end else if (left != '0) begin
      left   <= left - 1'b1;
    end
  end

  assign busy = (left != '0);

  assert_win_opens_on_read_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(rd_issue));

  assert_win_closes_on_stop_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(stop) && !$past(rd_issue)) |-> !busy);

endmodule

// File: rtl/ddr_rw_turnaround.sv
module ddr_rw_turnaround
  import ddr_turn_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 13,
  parameter int CL     = 2,
  parameter int BL     = 4,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 3,
  parameter int T_BSTW = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_req,
  input  logic [$clog2(NBANK)-1:0] rd_bank,
  input  logic [ROW_W-1:0]         rd_row,
  input  logic                     wr_req,
  input  logic [$clog2(NBANK)-1:0] wr_bank,
  input  logic [ROW_W-1:0]         wr_row,
  output logic                     rd_gnt,
  output logic                     wr_gnt,
  output logic [2:0]               cmd,
  output logic [$clog2(NBANK)-1:0] cmd_bank,
  output logic [ROW_W-1:0]         cmd_row
);
  localparam int BANK_W  = $clog2(NBANK);
  localparam int T_BW    = (T_BSTW < CL) ? CL : T_BSTW;
  localparam int WIN     = CL + BL / 2;
  localparam int TMAX_A  = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TMAX    = (TMAX_A > T_BW) ? TMAX_A : T_BW;
  localparam int TCW     = $clog2(TMAX + 1);
  localparam int SCW     = $clog2(TMAX + 2);

  seq_st_e st, st_n;
  cmd_e    cmd_q, nxt_cmd, step_cmd;
  seq_st_e step_st;
  logic    step_ld, step_fin;
  logic [TCW-1:0] step_val;

  logic              op_wr;
  logic [BANK_W-1:0] op_bank;
  logic [ROW_W-1:0]  op_row;
  logic              cur_wr;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;

  logic q_open, q_hit;
  logic win_busy;
  logic [BANK_W-1:0] win_bank;
  logic [ROW_W-1:0]  win_row;
  logic tm_done, tm_ld, fin, take, need_bst;
  logic [TCW-1:0] tm_val;

  // The operation in flight: the live request in IDLE, the latched one after.
  always_comb begin
    if (st == S_IDLE) begin
      cur_wr   = wr_req;
      cur_bank = wr_req ? wr_bank : rd_bank;
      cur_row  = wr_req ? wr_row  : rd_row;
    end else begin
      cur_wr   = op_wr;
      cur_bank = op_bank;
      cur_row  = op_row;
    end
  end

  assign need_bst = cur_wr && win_busy &&
                    ((cur_bank != win_bank) || (cur_row == win_row));

  // Next step toward an access on the target bank.
  always_comb begin
    step_ld  = 1'b0;
    step_fin = 1'b0;
    step_val = '0;
    if (q_open && q_hit) begin
      step_cmd = cur_wr ? CMD_WRIT : CMD_READ;
      step_st  = S_HOLD;
      step_fin = 1'b1;
    end else if (q_open) begin
      step_cmd = CMD_PRE;
      step_st  = S_PREW;
      step_ld  = 1'b1;
      step_val = TCW'(T_RP - 1);
    end else begin
      step_cmd = CMD_ACT;
      step_st  = S_ACTW;
      step_ld  = 1'b1;
      step_val = TCW'(T_RCD - 1);
    end
  end

  always_comb begin
    nxt_cmd = CMD_NOP;
    st_n    = st;
    tm_ld   = 1'b0;
    tm_val  = '0;
    fin     = 1'b0;
    take    = 1'b0;
    case (st)
      S_IDLE: begin
        if (wr_req || rd_req) begin
          take = 1'b1;
          if (need_bst) begin
            nxt_cmd = CMD_BST;
            st_n    = S_BSTW;
            tm_ld   = 1'b1;
            tm_val  = TCW'(T_BW - 1);
          end else begin
            nxt_cmd = step_cmd;
            st_n    = step_st;
            tm_ld   = step_ld;
            tm_val  = step_val;
            fin     = step_fin;
          end
        end
      end
      S_BSTW, S_ACTW: begin
        if (tm_done) begin
          nxt_cmd = step_cmd;
          st_n    = step_st;
          tm_ld   = step_ld;
          tm_val  = step_val;
          fin     = step_fin;
        end
      end
      S_PREW: begin
        if (tm_done) begin
          nxt_cmd = CMD_ACT;
          st_n    = S_ACTW;
          tm_ld   = 1'b1;
          tm_val  = TCW'(T_RCD - 1);
        end
      end
      S_HOLD:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cmd_q    <= CMD_NOP;
      cmd_bank <= '0;
      cmd_row  <= '0;
      wr_gnt   <= 1'b0;
      rd_gnt   <= 1'b0;
      op_wr    <= 1'b0;
      op_bank  <= '0;
      op_row   <= '0;
    end else begin
      st       <= st_n;
      cmd_q    <= nxt_cmd;
      cmd_bank <= (nxt_cmd != CMD_NOP) ? cur_bank : '0;
      cmd_row  <= (nxt_cmd != CMD_NOP) ? cur_row  : '0;
      wr_gnt   <= fin && cur_wr;
      rd_gnt   <= fin && !cur_wr;
      if (take) begin
        op_wr   <= cur_wr;
        op_bank <= cur_bank;
        op_row  <= cur_row;
      end
    end
  end

  assign cmd = cmd_q;

  ddr_bank_table #(.NBANK(NBANK), .ROW_W(ROW_W)) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .act_en (nxt_cmd == CMD_ACT),
    .pre_en (nxt_cmd == CMD_PRE),
    .rw_en  (nxt_cmd == CMD_READ || nxt_cmd == CMD_WRIT),
    .c_bank (cur_bank),
    .c_row  (cur_row),
    .q_bank (cur_bank),
    .q_row  (cur_row),
    .q_open (q_open),
    .q_hit  (q_hit)
  );

  ddr_gap_timer #(.CW(TCW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tm_ld),
    .load_val (tm_val),
    .done     (tm_done)
  );

  ddr_read_window #(.WIN(WIN), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .rd_issue (nxt_cmd == CMD_READ),
    .stop     (nxt_cmd == CMD_BST || nxt_cmd == CMD_PRE),
    .i_bank   (cur_bank),
    .i_row    (cur_row),
    .busy     (win_busy),
    .r_bank   (win_bank),
    .r_row    (win_row)
  );

  // Spacing monitors: cycles since the last BST, PRE and ACT on the bus.
  localparam logic [SCW-1:0] SMAX = '1;
  logic [SCW-1:0] since_bst, since_pre, since_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_bst <= SMAX;
      since_pre <= SMAX;
      since_act <= SMAX;
    end else begin
      since_bst <= (cmd_q == CMD_BST) ? SCW'(1) : (since_bst == SMAX ? SMAX : since_bst + 1'b1);
      since_pre <= (cmd_q == CMD_PRE) ? SCW'(1) : (since_pre == SMAX ? SMAX : since_pre + 1'b1);
      since_act <= (cmd_q == CMD_ACT) ? SCW'(1) : (since_act == SMAX ? SMAX : since_act + 1'b1);
    end
  end

  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_READ || cmd_q == CMD_WRIT) |-> since_act >= SCW'(T_RCD));

  assert_rp_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT) |-> since_pre >= SCW'(T_RP));

  assert_bst_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_WRIT) |-> since_bst >= SCW'(T_BW));

  assert_wr_gnt_with_writ_R6: assert property (@(posedge clk) disable iff (rst)
    wr_gnt |-> (cmd_q == CMD_WRIT));

  assert_rd_gnt_with_read_R5: assert property (@(posedge clk) disable iff (rst)
    rd_gnt |-> (cmd_q == CMD_READ));

  assert_quiet_after_gnt_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_gnt || rd_gnt) |=> (cmd_q == CMD_NOP && !wr_gnt && !rd_gnt));

endmodule

// File: tb/sim_ddr_rw_turnaround.sv
module sim_ddr_rw_turnaround;
  localparam int NB    = 4;
  localparam int BW    = 2;
  localparam int RW    = 8;
  localparam int CL    = 2;
  localparam int BL    = 4;
  localparam int TRP   = 3;
  localparam int TRCD  = 4;
  localparam int TBSTW = 1;
  localparam int T_BW  = (TBSTW < CL) ? CL : TBSTW;
  localparam int WIN   = CL + BL / 2;

  localparam int C_NOP = 0, C_READ = 1, C_WRIT = 2, C_BST = 3, C_PRE = 4, C_ACT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic [BW-1:0] rd_bank = '0, wr_bank = '0;
  logic [RW-1:0] rd_row = '0, wr_row = '0;
  logic rd_gnt, wr_gnt;
  logic [2:0] cmd;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Bench reference model
  bit m_open [NB];
  int m_row  [NB];
  bit rv = 0;
  int re = 0, rb = 0, rr = 0;

  ddr_rw_turnaround #(
    .NBANK(NB), .ROW_W(RW), .CL(CL), .BL(BL),
    .T_RP(TRP), .T_RCD(TRCD), .T_BSTW(TBSTW)
  ) u0 (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_row(rd_row),
    .wr_req(wr_req), .wr_bank(wr_bank), .wr_row(wr_row),
    .rd_gnt(rd_gnt), .wr_gnt(wr_gnt),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_op(input bit w, input int b, input int r, input int idle);
    int ec [4];
    int eg [4];
    int n, g, d, raise, last, got;
    bit busy, done;
    string tag, sp;
    n = 0;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      chk(cmd == C_NOP, "R2 idle slot not NOP", cmd, C_NOP);
    end
    raise = cyc;
    d = raise + 1;
    busy = rv && ((d - re) <= WIN);
    if (w && busy && (b != rb || r == rr)) begin
      ec[0] = C_BST; eg[0] = 1; n = 1;
      tag = (b == rb) ? "R6" : "R8";
    end else if (w && busy) begin
      tag = "R7";
    end else if (w) begin
      tag = "R10";
    end else if (m_open[b] && m_row[b] == r) begin
      tag = "R5";
    end else if (m_open[b]) begin
      tag = "R4";
    end else begin
      tag = "R3";
    end
    g = (n == 0) ? 1 : T_BW;
    if (m_open[b] && m_row[b] == r) begin
      ec[n] = w ? C_WRIT : C_READ; eg[n] = g; n++;
    end else if (m_open[b]) begin
      ec[n] = C_PRE; eg[n] = g; n++;
      ec[n] = C_ACT; eg[n] = TRP; n++;
      ec[n] = w ? C_WRIT : C_READ; eg[n] = TRCD; n++;
    end else begin
      ec[n] = C_ACT; eg[n] = g; n++;
      ec[n] = w ? C_WRIT : C_READ; eg[n] = TRCD; n++;
    end
    if (w) begin wr_req = 1; wr_bank = BW'(b); wr_row = RW'(r); end
    else   begin rd_req = 1; rd_bank = BW'(b); rd_row = RW'(r); end
    last = raise; got = 0; done = 0;
    for (int t = 0; t < 100 && !done; t++) begin
      @(negedge clk);
      if (cmd != C_NOP) begin
        if (got < n) begin
          sp = (got > 0 && ec[got-1] == C_BST) ? "R9" : tag;
          chk(cmd == ec[got], {tag, " command code"}, cmd, ec[got]);
          chk(cyc - last == eg[got], {sp, " command spacing"}, cyc - last, eg[got]);
          chk(cmd_bank == BW'(b) && cmd_row == RW'(r), {"R2 command bank/row ", tag}, cmd_bank, b);
        end else begin
          chk(0, {tag, " extra command"}, cmd, C_NOP);
        end
        last = cyc;
        got++;
      end
      if (w ? wr_gnt : rd_gnt) begin
        done = 1;
        chk(got == n, {tag, " command count at grant"}, got, n);
        chk(cmd == (w ? C_WRIT : C_READ), {tag, " grant without access"}, cmd, w ? C_WRIT : C_READ);
        wr_req = 0; rd_req = 0;
      end else if (w ? rd_gnt : wr_gnt) begin
        chk(0, {tag, " wrong grant"}, 1, 0);
      end
    end
    if (!done) begin
      chk(0, {tag, " grant never seen"}, got, n);
      wr_req = 0; rd_req = 0;
    end
    for (int i = 0; i < n; i++) begin
      case (ec[i])
        C_ACT:  begin m_open[b] = 1; m_row[b] = r; end
        C_PRE:  begin m_open[b] = 0; rv = 0; end
        C_BST:  rv = 0;
        C_READ: begin rv = 1; re = last; rb = b; rr = r; end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int x;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; end
    repeat (4) @(negedge clk);
    chk(cmd == C_NOP && !rd_gnt && !wr_gnt, "R1 outputs during reset", cmd, C_NOP);
    rst = 0;
    @(negedge clk);
    chk(cmd == C_NOP && !rd_gnt && !wr_gnt, "R1 outputs after reset", cmd, C_NOP);

    run_op(0, 0, 5, 1);   // R3 read to closed bank
    run_op(1, 0, 5, 1);   // R6 same bank same row interrupt, R9 clamp
    run_op(0, 0, 5, 1);   // R5 read hit
    run_op(1, 0, 9, 1);   // R7 same bank other row
    run_op(0, 1, 3, 1);   // R3 closed bank 1
    run_op(1, 0, 9, 1);   // R8 other bank, target open on row
    run_op(0, 1, 3, 1);   // R5 hit
    run_op(1, 2, 4, 1);   // R8 other bank, target closed
    run_op(0, 2, 7, 1);   // R4 open on other row
    run_op(0, 2, 7, 1);   // R5
    run_op(1, 2, 7, 3);   // R10 last edge inside the window -> BST
    run_op(0, 2, 7, 1);
    run_op(1, 2, 7, 4);   // R10 first edge outside the window -> plain WRIT

    // R12: request held through the cycle after its grant
    repeat (6) @(negedge clk);
    rd_req = 1; rd_bank = 2'd2; rd_row = 8'd7;
    @(negedge clk);
    x = cyc;
    chk(cmd == C_READ && rd_gnt, "R12 read hit granted", cmd, C_READ);
    @(negedge clk);
    chk(cmd == C_NOP && !rd_gnt && !wr_gnt, "R12 held request ignored after grant", cmd, C_NOP);
    rd_req = 0;
    @(negedge clk);
    chk(cmd == C_NOP && !rd_gnt, "R12 no repeat after grant", cmd, C_NOP);
    rv = 1; re = x; rb = 2; rr = 7;

    // R11: both requests at once, write first
    repeat (6) @(negedge clk);
    wr_req = 1; wr_bank = 2'd2; wr_row = 8'd7;
    rd_req = 1; rd_bank = 2'd1; rd_row = 8'd3;
    @(negedge clk);
    chk(cmd == C_WRIT && wr_gnt && !rd_gnt, "R11 write served first", cmd, C_WRIT);
    wr_req = 0;
    @(negedge clk);
    chk(cmd == C_NOP, "R11 gap after write grant", cmd, C_NOP);
    @(negedge clk);
    chk(cmd == C_READ && rd_gnt, "R11 read served second", cmd, C_READ);
    x = cyc;
    rd_req = 0;
    rv = 1; re = x; rb = 1; rr = 3;

    for (int k = 0; k < 60; k++) begin
      run_op(1'($urandom % 2), int'($urandom % NB), 5 + int'($urandom % 3), 1 + int'($urandom % 5));
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule